// File: doc/BRIEF.md
# Ring Carry-Feedback Key Generator

This block produces 128-bit key words from a feedback-with-carry shift register arranged as a ring. The main register rotates one position per step toward cell 0. At a set of tap positions chosen by a compile-time mask, the bit entering the cell is not a plain copy. It is the low bit of an integer sum of three terms: the neighbouring cell, a second cell a fixed distance around the ring, and a carry bit held at that tap. The high bit of the sum becomes the tap's new carry. Each tap reads a different cell, so the feedback is spread around the ring. No single cell drives every tap, and no single tap reads every cell.

A seed load fills the ring and clears all carries. While the enable is high the ring steps once per clock. The bit leaving cell 0 on each step is collected into a key word. After 128 steps the word is published on the key output, and a one-cycle ready pulse marks it. Generation then continues, and a fresh key appears every 128 enabled steps. The same published key serves both the encrypt and decrypt key-expansion paths downstream.

Top module: `fcsr_key_gen`

## Requirements
- R1: While rst_ni is low, key_o reads all zeros and key_ready_o is low.
- R2: A cycle with load_i high copies seed_i into the ring, zeroes every carry, restarts key collection and drives key_ready_o low on the next cycle; load_i takes priority over en_i.
- R3: A seed_i of all zeros is loaded as the value 1, that is, bit 0 set and every other bit clear.
- R4: On each enabled step, a cell i whose bit is clear in FB_MASK takes cell (i+1) mod 128. A cell i whose mask bit is set takes bit 0 of cell(i+1) + cell((i+FB_SKIP) mod 128) + carry_i, and carry_i takes bit 1 of that sum.
- R5: The bit collected on a step is cell 0 as it stood before that step; bit k of a key word is the bit from the k-th step (k = 0 first) of that word.
- R6: key_ready_o is high for exactly the one cycle that follows the 128th enabled step of a word; key_o takes the new word on that same clock edge and holds it until the next word completes.
- R7: While en_i and load_i are both low, the ring, carries and collection count are held, key_o is unchanged and key_ready_o is low.
- R8: Without a new load, generation continues and a further key word is published after every additional 128 enabled steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load seed_i into the ring |
| seed_i | input | KEY_W | Seed value |
| en_i | input | 1 | Step the ring this cycle |
| key_o | output | KEY_W | Last completed key word |
| key_ready_o | output | 1 | One-cycle pulse when key_o is updated |

## Verification
The carry cells are the hardest part of this block to observe. They are never visible at the ports. A carry mistake surfaces only as a wrong key bit many steps later, after it has propagated through the ring. The bench therefore runs a bit-exact model of the ring and its carries in step with the design. It compares key_o and key_ready_o on every cycle across several seeds, including dense seeds that make carries frequent and an all-zero seed. Irregular enable patterns, a long stall and a reload in mid-word are mixed in, so that counting and hold behaviour is exercised at the ports.

// File: rtl/fkg_pkg.sv
package fkg_pkg;
  parameter logic [127:0] FKG_DEF_TAPS =
      (128'd1 << 3)  | (128'd1 << 22) | (128'd1 << 41) | (128'd1 << 58) |
      (128'd1 << 77) | (128'd1 << 90) | (128'd1 << 109) | (128'd1 << 123);
  parameter int unsigned FKG_DEF_SKIP = 37;
endpackage

// File: rtl/fkg_ring_core.sv
module fkg_ring_core #(
  parameter int unsigned     N    = 128,
  parameter logic [N-1:0]    MASK = '0,
  parameter int unsigned     SKIP = 37
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] seed_i,
  input  logic         step_i,
  output logic         out_bit_o
);
  logic [N-1:0] cell_q, cell_d, seed_fix;

  // all-zero seed would lock the ring at zero
  assign seed_fix = seed_i | {{(N-1){1'b0}}, ~|seed_i};

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam int unsigned NXT = (i + 1) % N;
    localparam int unsigned FBS = (i + SKIP) % N;
    if (MASK[i]) begin : g_tap
      logic       carry_q;
      logic [1:0] sum;
      assign sum = 2'(cell_q[NXT]) + 2'(cell_q[FBS]) + 2'(carry_q);
      assign cell_d[i] = sum[0];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     carry_q <= 1'b0;
        else if (load_i) carry_q <= 1'b0;
        else if (step_i) carry_q <= sum[1];
      end
    end else begin : g_shift
      assign cell_d[i] = cell_q[NXT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cell_q <= {{(N-1){1'b0}}, 1'b1};
    else if (load_i) cell_q <= seed_fix;
    else if (step_i) cell_q <= cell_d;
  end

  assign out_bit_o = cell_q[0];
endmodule

// File: rtl/fkg_key_collector.sv
module fkg_key_collector #(
  parameter int unsigned W = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         bit_i,
  output logic [W-1:0] key_o,
  output logic         ready_o
);
  localparam int unsigned CNT_W = $clog2(W);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     coll_q, coll_nxt;
  logic             last;

  assign coll_nxt = {bit_i, coll_q[W-1:1]};
  assign last     = (cnt_q == CNT_W'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      coll_q  <= '0;
      key_o   <= '0;
      ready_o <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= '0;
      coll_q  <= '0;
      ready_o <= 1'b0;
    end else if (step_i) begin
      coll_q  <= coll_nxt;
      ready_o <= last;
      if (last) begin
        key_o <= coll_nxt;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      ready_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fcsr_key_gen.sv
module fcsr_key_gen #(
  parameter int unsigned        KEY_W   = 128,
  parameter logic [KEY_W-1:0]   FB_MASK = KEY_W'(fkg_pkg::FKG_DEF_TAPS),
  parameter int unsigned        FB_SKIP = fkg_pkg::FKG_DEF_SKIP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] seed_i,
  input  logic             en_i,
  output logic [KEY_W-1:0] key_o,
  output logic             key_ready_o
);
  logic out_bit;

  fkg_ring_core #(.N(KEY_W), .MASK(FB_MASK), .SKIP(FB_SKIP)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .seed_i   (seed_i),
    .step_i   (en_i),
    .out_bit_o(out_bit)
  );

  fkg_key_collector #(.W(KEY_W)) u_coll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .step_i (en_i),
    .bit_i  (out_bit),
    .key_o  (key_o),
    .ready_o(key_ready_o)
  );
endmodule

// File: rtl/fcsr_key_gen_chk.sv
module fcsr_key_gen_chk #(
  parameter int unsigned KEY_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             en_i,
  input logic [KEY_W-1:0] key_o,
  input logic             key_ready_o
);
  localparam int unsigned CW = $clog2(KEY_W);

  logic [CW-1:0] steps_q;
  logic          due_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steps_q <= '0;
      due_q   <= 1'b0;
    end else if (load_i) begin
      steps_q <= '0;
      due_q   <= 1'b0;
    end else if (en_i) begin
      steps_q <= steps_q + 1'b1;
      due_q   <= (steps_q == CW'(KEY_W - 1));
    end else begin
      due_q   <= 1'b0;
    end
  end

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ready_o |=> !key_ready_o);

  assert_key_only_on_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(key_o) |-> key_ready_o);

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> ($stable(key_o) && !key_ready_o));

  assert_load_clears_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !key_ready_o);

  assert_ready_every_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ready_o == due_q);
endmodule

bind fcsr_key_gen fcsr_key_gen_chk #(.KEY_W(KEY_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .en_i       (en_i),
  .key_o      (key_o),
  .key_ready_o(key_ready_o)
);

// File: tb/fcsr_key_gen_tb.sv
module fcsr_key_gen_tb;
  localparam int unsigned W    = 128;
  localparam int unsigned SKIP = 37;
  localparam logic [W-1:0] MASK =
      (128'd1 << 3)  | (128'd1 << 22) | (128'd1 << 41) | (128'd1 << 58) |
      (128'd1 << 77) | (128'd1 << 90) | (128'd1 << 109) | (128'd1 << 123);

  localparam int NV = 4;
  // stimulus: seed and stall period (0 = never stall); expected from model
  localparam logic [W-1:0] VSEED [NV] = '{
    128'h0123456789abcdef_fedcba9876543210,
    128'hffffffffffffffff_ffffffffffffffff,
    128'h0000000000000000_0000000000000001,
    128'h90876543245678909dcfae3456fdea74
  };
  localparam int VGAP [NV] = '{0, 3, 0, 5};

  logic clk_i = 1'b0, rst_ni = 1'b0, load_i = 1'b0, en_i = 1'b0;
  logic [W-1:0] seed_i = '0;
  logic [W-1:0] key_o;
  logic key_ready_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model
  logic [W-1:0] m_cell, m_carry, m_coll, m_key;
  logic m_ready;
  int m_cnt;

  always #5 clk_i = ~clk_i;

  fcsr_key_gen #(.KEY_W(W), .FB_MASK(MASK), .FB_SKIP(SKIP)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .seed_i(seed_i),
    .en_i(en_i), .key_o(key_o), .key_ready_o(key_ready_o)
  );

  task automatic model_edge(input logic ld, input logic [W-1:0] sd, input logic en);
    logic [W-1:0] nc, ncar;
    logic [1:0] s;
    logic ob;
    if (ld) begin
      m_cell  = (sd == '0) ? W'(1) : sd;
      m_carry = '0; m_coll = '0; m_cnt = 0; m_ready = 1'b0;
    end else if (en) begin
      ob = m_cell[0];
      ncar = m_carry;
      for (int i = 0; i < W; i++) begin
        if (MASK[i]) begin
          s = 2'(m_cell[(i+1)%W]) + 2'(m_cell[(i+SKIP)%W]) + 2'(m_carry[i]);
          nc[i] = s[0]; ncar[i] = s[1];
        end else begin
          nc[i] = m_cell[(i+1)%W];
        end
      end
      m_cell = nc; m_carry = ncar;
      m_coll = {ob, m_coll[W-1:1]};
      if (m_cnt == W-1) begin
        m_key = m_coll; m_ready = 1'b1; m_cnt = 0;
      end else begin
        m_cnt++; m_ready = 1'b0;
      end
    end else begin
      m_ready = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(key_o == m_key, {tag, " key"}, key_o, m_key);
    check(key_ready_o == m_ready, {tag, " ready"}, W'(key_ready_o), W'(m_ready));
  endtask

  // called at a negedge; ends at the next negedge
  task automatic cyc(input logic ld, input logic [W-1:0] sd, input logic en, input string tag);
    load_i = ld; seed_i = sd; en_i = en;
    @(posedge clk_i);
    model_edge(ld, sd, en);
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic run(input int n, input int gap, input string tag);
    for (int k = 0; k < n; k++)
      cyc(1'b0, '0, (gap == 0) ? 1'b1 : ((k % gap) != gap - 1), tag);
  endtask

  initial begin
    #1;
    check(key_o == '0, "R1 reset key", key_o, '0);
    check(key_ready_o == 1'b0, "R1 reset ready", W'(key_ready_o), '0);
    m_key = '0; m_ready = 1'b0; m_cell = W'(1); m_carry = '0; m_coll = '0; m_cnt = 0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      cyc(1'b1, VSEED[v], 1'b1, "R2 load with enable");
      run(2 * W + 40, VGAP[v], "R4 R5 R6 R8 stream");
    end

    // R3: all-zero seed behaves as seed 1
    cyc(1'b1, '0, 1'b0, "R3 zero seed load");
    run(W + 3, 0, "R3 zero seed key");

    // R7: long stall in mid-word
    cyc(1'b1, 128'hdeadbeef_00ff00ff_a5a5a5a5_13579bdf, 1'b0, "R2 load");
    run(50, 0, "R7 pre-stall");
    for (int k = 0; k < 60; k++) cyc(1'b0, '0, 1'b0, "R7 stall hold");
    run(W, 0, "R7 post-stall");

    // R2: reload in mid-word restarts the count
    run(60, 0, "R8 partial");
    cyc(1'b1, 128'h0f0f0f0f_f0f0f0f0_33333333_cccccccc, 1'b1, "R2 reload");
    run(W + 5, 2, "R2 after reload");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog timeout");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule